// File: doc/BRIEF.md
# Bus Access Slicer

The slicer sits in front of a memory controller that only understands three shapes of transfer: a four-beat burst covering one 64-byte line, a single covering one whole 16-byte word, and a partial covering 1 to 15 bytes inside one 16-byte word. An upstream master hands the slicer one access: a start byte address, a byte length and a read/write flag. The slicer turns it into the shortest sequence of legal sub-accesses that covers exactly those bytes. Each sub-access carries a word-aligned address, a type code and per-byte enables.

The sequence is fixed by the alignment of the access. Bytes before the first 16-byte boundary go out first as a partial. Each 64-byte line that the access covers completely goes out as one burst. Whole words that do not fill a line go out as singles. Bytes after the last word boundary go out last as a partial. Both sides use a valid/ready handshake. A new access is taken only once the last sub-access of the previous one has been accepted downstream. A zero-length access is refused with a one-cycle error pulse.

Top module: `access_slicer`

## Requirements
- R1: While reset is asserted and after its release, with no request presented, `in_ready` is 1, `out_valid` is 0 and `in_err` is 0.
- R2: A request with length 0 that is accepted produces `in_err` = 1 for exactly the next cycle, emits no sub-access, and leaves `in_ready` at 1.
- R3: When the start address is not 16-byte aligned, the first sub-access is a partial (`out_kind` = 0). Its address is the start address with the low 4 bits cleared. Bit i of `out_be` is set for i from the start offset up to min(offset + length, 16) - 1.
- R4: When the running address is 64-byte aligned and at least 64 bytes remain, a burst is issued (`out_kind` = 2). Its address has the low 6 bits zero and all 16 enables are set. This holds for reads and writes alike.
- R5: When the running address is 16-byte aligned, at least 16 bytes remain, and a burst does not apply, a single is issued (`out_kind` = 1) with all 16 enables set.
- R6: When the running address is 16-byte aligned and fewer than 16 bytes remain, the final sub-access is a partial (`out_kind` = 0) whose enables are bits 0 to remaining - 1.
- R7: Sub-accesses come in ascending address order with no gap and no overlap. Their byte counts sum to the request length. `out_kind` never takes the value 3.
- R8: While `out_valid` is 1 and `out_ready` is 0, the address, type, enables and write flag stay unchanged and `out_valid` stays 1.
- R9: `in_ready` is 0 from the cycle after a non-zero request is accepted until the last sub-access has been taken. It is 1 in the cycle after that, when `out_valid` is 0.
- R10: Every sub-access carries the write flag of the request it came from on `out_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream request present |
| in_ready | output | 1 | Slicer idle and able to take a request |
| in_addr | input | ADDR_W | Start byte address |
| in_len | input | LEN_W | Byte length |
| in_write | input | 1 | 1 = write, 0 = read |
| in_err | output | 1 | One-cycle pulse after a zero-length request is taken |
| out_valid | output | 1 | Sub-access present |
| out_ready | input | 1 | Controller takes the sub-access |
| out_addr | output | ADDR_W | Word-aligned sub-access address |
| out_kind | output | 2 | 0 partial, 1 single, 2 burst |
| out_be | output | WORD_B | Byte enables, bit i = byte i of the word |
| out_write | output | 1 | Write flag of the sub-access |

## Verification
The bench builds the slicer with a 12-bit address and an 8-bit length. These narrow widths make it practical to sweep every start offset inside a 64-byte line against every length from 0 to 150. That range covers zero-length refusal, accesses confined to one word, accesses that straddle words without filling one, and accesses holding up to two whole lines with leading and trailing fragments. A pseudo-random stall pattern on the downstream ready exercises holding of the output under backpressure for every kind of sub-access.

// File: rtl/slicer_pkg.sv
package slicer_pkg;

  // Sub-access type code driven on out_kind.
  typedef enum logic [1:0] {
    KIND_PART = 2'd0,
    KIND_WORD = 2'd1,
    KIND_LINE = 2'd2
  } sub_kind_e;

endpackage

// File: rtl/slicer_be_mask.sv
// Byte-enable mask: set bits [off, off+cnt) of one word.
module slicer_be_mask #(
  parameter int WORD_B = 16,
  parameter int OFF_W  = $clog2(WORD_B),
  parameter int CNT_W  = OFF_W + 1
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [CNT_W-1:0]  cnt,
  output logic [WORD_B-1:0] be
);

  localparam int EW = CNT_W + 1;

  logic [EW-1:0] lo;
  logic [EW-1:0] hi;

  always_comb begin
    lo = EW'(off);
    hi = EW'(off) + EW'(cnt);
  end

  for (genvar g = 0; g < WORD_B; g++) begin : g_lane
    assign be[g] = (EW'(g) >= lo) && (EW'(g) < hi);
  end

endmodule

// File: rtl/slicer_step.sv
// Chooses the next legal sub-access from the running address and remaining length.
module slicer_step
  import slicer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int WORD_B = 16,
  parameter int LINE_B = 64,
  parameter int STEP_W = $clog2(LINE_B) + 1
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  rem_len,
  output sub_kind_e         kind,
  output logic [STEP_W-1:0] step_len,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [WORD_B-1:0] sub_be
);

  localparam int WOFF_W = $clog2(WORD_B);
  localparam int LOFF_W = $clog2(LINE_B);
  localparam int CNT_W  = WOFF_W + 1;

  logic [WOFF_W-1:0] off;
  logic [CNT_W-1:0]  room;
  logic [CNT_W-1:0]  part_cnt;
  logic              short_rem;
  logic              line_ok;
  logic [WOFF_W-1:0] mask_off;
  logic [CNT_W-1:0]  mask_cnt;

  always_comb begin
    off       = cur_addr[WOFF_W-1:0];
    room      = CNT_W'(WORD_B) - CNT_W'(off);
    short_rem = rem_len < LEN_W'(WORD_B);
    line_ok   = (cur_addr[LOFF_W-1:0] == '0) && (rem_len >= LEN_W'(LINE_B));
    part_cnt  = (rem_len < LEN_W'(room)) ? CNT_W'(rem_len) : room;

    if ((off != '0) || short_rem) begin
      kind     = KIND_PART;
      step_len = STEP_W'(part_cnt);
      mask_off = off;
      mask_cnt = part_cnt;
    end else if (line_ok) begin
      kind     = KIND_LINE;
      step_len = STEP_W'(LINE_B);
      mask_off = '0;
      mask_cnt = CNT_W'(WORD_B);
    end else begin
      kind     = KIND_WORD;
      step_len = STEP_W'(WORD_B);
      mask_off = '0;
      mask_cnt = CNT_W'(WORD_B);
    end

    sub_addr = {cur_addr[ADDR_W-1:WOFF_W], {WOFF_W{1'b0}}};
  end

  slicer_be_mask #(
    .WORD_B (WORD_B),
    .OFF_W  (WOFF_W),
    .CNT_W  (CNT_W)
  ) u_mask (
    .off (mask_off),
    .cnt (mask_cnt),
    .be  (sub_be)
  );

endmodule

// File: rtl/access_slicer.sv
// Splits one arbitrary access into legal burst / single / partial sub-accesses.
module access_slicer
  import slicer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int WORD_B = 16,
  parameter int LINE_B = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_write,
  output logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_kind,
  output logic [WORD_B-1:0] out_be,
  output logic              out_write
);

  localparam int LOFF_W = $clog2(LINE_B);
  localparam int STEP_W = LOFF_W + 1;

  // State registers
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              wr_q, wr_d;
  logic              err_q, err_d;
  logic              ld_en;

  // Step decision
  sub_kind_e         kind;
  logic [STEP_W-1:0] step_len;
  logic [ADDR_W-1:0] sub_addr;
  logic [WORD_B-1:0] sub_be;

  logic take_in;
  logic take_out;

  slicer_step #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .WORD_B (WORD_B),
    .LINE_B (LINE_B),
    .STEP_W (STEP_W)
  ) u_step (
    .cur_addr (cur_q),
    .rem_len  (rem_q),
    .kind     (kind),
    .step_len (step_len),
    .sub_addr (sub_addr),
    .sub_be   (sub_be)
  );

  // Next-state logic
  always_comb begin
    take_in  = in_valid && !busy_q;
    take_out = busy_q && out_ready;

    busy_d = busy_q;
    cur_d  = cur_q;
    rem_d  = rem_q;
    wr_d   = wr_q;
    err_d  = 1'b0;
    ld_en  = 1'b0;

    if (take_in) begin
      if (in_len == '0) begin
        err_d = 1'b1;
      end else begin
        ld_en  = 1'b1;
        busy_d = 1'b1;
        cur_d  = in_addr;
        rem_d  = in_len;
        wr_d   = in_write;
      end
    end else if (take_out) begin
      ld_en = 1'b1;
      cur_d = cur_q + ADDR_W'(step_len);
      rem_d = rem_q - LEN_W'(step_len);
      if (rem_q == LEN_W'(step_len)) begin
        busy_d = 1'b0;
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  // Data registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      rem_q <= '0;
      wr_q  <= 1'b0;
    end else if (ld_en) begin
      cur_q <= cur_d;
      rem_q <= rem_d;
      wr_q  <= wr_d;
    end
  end

  assign in_ready  = !busy_q;
  assign in_err    = err_q;
  assign out_valid = busy_q;
  assign out_addr  = sub_addr;
  assign out_kind  = kind;
  assign out_be    = sub_be;
  assign out_write = wr_q;

  // R4: bursts are line aligned with every lane enabled
  a_r4_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd2) |-> (out_addr[LOFF_W-1:0] == '0) && (&out_be));

  // R5: singles enable the whole word
  a_r5_word_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd1) |-> (&out_be));

  // R3 / R6: partials enable some but not all lanes
  a_r3_part_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd0) |-> (out_be != '0) && !(&out_be));

  // R7: type code stays within the legal set
  a_r7_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_kind != 2'd3));

  // R8: held output under backpressure
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_addr) && $stable(out_kind)
                                  && $stable(out_be) && $stable(out_write));

  // R2: error pulse only follows a taken zero-length request, with nothing emitted
  a_r2_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    in_err |-> $past(in_valid && in_ready && (in_len == '0)) && !out_valid);

endmodule

// File: tb/access_slicer_tb_top.sv
module access_slicer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int LW = 8;
  localparam int WB = 16;
  localparam int LB = 64;
  localparam int MAX_LEN = 150;
  localparam int BASE = 256;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [AW-1:0] in_addr;
  logic [LW-1:0] in_len;
  logic          in_write;
  logic          in_err;
  logic          out_valid;
  logic          out_ready;
  logic [AW-1:0] out_addr;
  logic [1:0]    out_kind;
  logic [WB-1:0] out_be;
  logic          out_write;

  int checks = 0;
  int errors = 0;
  int seed   = 7;

  always #(CLK_PERIOD/2) clk = ~clk;

  access_slicer #(
    .ADDR_W (AW),
    .LEN_W  (LW),
    .WORD_B (WB),
    .LINE_B (LB)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_addr   (in_addr),
    .in_len    (in_len),
    .in_write  (in_write),
    .in_err    (in_err),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_kind  (out_kind),
    .out_be    (out_be),
    .out_write (out_write)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input int base, input int len, input bit wr);
    int cur;
    int rem;
    int off;
    int n;
    int ekind;
    int ebe;
    int eaddr;
    string tag;
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = AW'(base);
    in_len   = LW'(len);
    in_write = wr;
    check(in_ready == 1'b1, "R9", "in_ready idle", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    if (len == 0) begin
      check(in_err == 1'b1, "R2", "err pulse", in_err, 1);
      check(out_valid == 1'b0, "R2", "no sub-access", out_valid, 0);
      check(in_ready == 1'b1, "R2", "ready kept", in_ready, 1);
      @(negedge clk);
      check(in_err == 1'b0, "R2", "err one cycle", in_err, 0);
      check(out_valid == 1'b0, "R2", "still no sub-access", out_valid, 0);
      return;
    end
    cur = base;
    rem = len;
    while (rem > 0) begin
      off = cur % WB;
      if (off != 0 || rem < WB) begin
        n     = (rem < WB - off) ? rem : WB - off;
        ekind = 0;
        ebe   = ((1 << n) - 1) << off;
        eaddr = cur - off;
        tag   = (off != 0) ? "R3" : "R6";
      end else if ((cur % LB) == 0 && rem >= LB) begin
        n = LB; ekind = 2; ebe = 'hFFFF; eaddr = cur; tag = "R4";
      end else begin
        n = WB; ekind = 1; ebe = 'hFFFF; eaddr = cur; tag = "R5";
      end
      check(out_valid == 1'b1, "R7", "sub-access present", out_valid, 1);
      check(in_ready == 1'b0, "R9", "ready low while busy", in_ready, 0);
      check(out_addr == AW'(eaddr), tag, "address", out_addr, eaddr);
      check(out_kind == 2'(ekind), tag, "kind", out_kind, ekind);
      check(out_be == WB'(ebe), tag, "byte enables", out_be, ebe);
      check(out_write == wr, "R10", "write flag", out_write, wr);
      seed = seed * 1103515245 + 12345;
      if (((seed >> 16) & 3) == 0) begin
        out_ready = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R8", "valid held", out_valid, 1);
        check(out_addr == AW'(eaddr) && out_kind == 2'(ekind) && out_be == WB'(ebe)
              && out_write == wr, "R8", "fields held", out_be, ebe);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      cur = cur + n;
      rem = rem - n;
    end
    check(out_valid == 1'b0, "R7", "no extra sub-access", out_valid, 0);
    check(in_ready == 1'b1, "R9", "ready after last", in_ready, 1);
  endtask

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_addr   = '0;
    in_len    = '0;
    in_write  = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    check(in_err == 1'b0, "R1", "err in reset", in_err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && in_err == 1'b0, "R1",
          "idle after reset", {in_ready, out_valid, in_err}, 3'b100);
    for (int off = 0; off < LB; off++) begin
      for (int len = 0; len <= MAX_LEN; len++) begin
        run_req(BASE + off, len, 1'((off ^ len) & 1));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule